// File: doc/BRIEF.md
# Frame-Synced Serial Word Receiver

This block takes in words from one serial data line. A bit clock runs the whole time, and a frame-sync line runs beside the data. The block samples the serial clock, sync and data with its own system clock. It acts once per falling edge of the bit clock, because the far end changes its lines on the rising edge. A sync level seen at a falling edge means a word is on its way. The word's first data bit comes at the next falling edge. Each sync adds the two bytes of its word to a running count of bytes still owed.

Bits are collected most significant first. Every eighth collected bit completes a byte. The byte goes into a two-entry buffer that a consumer drains through a valid/ready handshake. Frames may follow one another with no gap. In that case the next sync is sampled on the same edge as the last bit of the current word, and both are applied together. A sync that lands while bytes are still owed leaves the partial byte intact and only raises the count. When no bytes are owed, arriving bits are dropped.

Top module: `frx_receiver`

## Requirements
- R1: An active-low synchronous reset clears the owed-byte count, the partial byte, the bit position, the output buffer and the overflow flag, so `byte_valid`, `bytes_owed` and `overflow` read 0 after reset.
- R2: One data bit is taken per falling edge of `ser_clk`, using the levels of `ser_sync` and `ser_data` held across that edge.
- R3: Suppose `ser_sync` is high at a falling edge while the owed count is 0. The count becomes 2, the partial byte and bit position are cleared, and the data level at that same edge is not part of the word. The next 16 falling edges carry the word.
- R4: Each word is shifted in most significant bit first. Its upper byte is delivered before its lower byte.
- R5: The owed count drops by one for each byte completed. Data bits sampled while the count is 0 and sync is low change nothing.
- R6: In a back-to-back stream, the next sync may be sampled on the same falling edge as the final bit of the current word. That bit still completes the current byte, and the count goes from 1 to 2 on that edge.
- R7: Suppose a sync is sampled while the owed count is non-zero. The bits already collected are kept, the count rises by 2, and the bit sampled on that edge is shifted in as data.
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` holds its value. The buffer holds two bytes.
- R9: Suppose a byte completes while the buffer holds two bytes and no byte leaves in that cycle. The byte is discarded and `overflow` is set, and only reset clears it.
- R10: `bytes_owed` changes only in the system-clock cycle that acts on a sampled falling edge of `ser_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Free-running serial bit clock |
| ser_sync | input | 1 | Frame-sync level, high one bit before a word |
| ser_data | input | 1 | Serial data line |
| byte_data | output | BYTE_W (8) | Byte at the head of the output buffer |
| byte_valid | output | 1 | Head byte present |
| byte_ready | input | 1 | Consumer accepts the head byte |
| bytes_owed | output | CNT_W (4) | Bytes announced by syncs but not yet completed |
| overflow | output | 1 | Sticky flag: a completed byte was dropped |

## Verification
The bench builds the block with its defaults: 16-bit words, 8-bit bytes, two synchronizer stages and a two-entry buffer. The bit clock runs at one-twelfth of the system clock. Two stages leave enough of the low half-period for a sampled edge to update the owed count before the bench reads it. A two-entry buffer can be filled by a single word, so one more word with the consumer stalled reaches the overflow case. With 8-bit bytes, a sync placed partway into a byte shows whether the partial byte is kept. A table of mixed gapped and back-to-back words reaches the case where a byte completion and a sync land on the same edge.

// File: rtl/frx_pkg.sv
package frx_pkg;

   // one observation of the serial lines, taken at a bit-clock falling edge
   typedef struct packed {
      logic strobe;   // a falling edge was seen this cycle
      logic sync;     // frame-sync level at that edge
      logic data;     // data level at that edge
   } frx_sample_t;

endpackage

// File: rtl/frx_edge_sampler.sv
module frx_edge_sampler
   import frx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ser_clk,
   input  logic        ser_sync,
   input  logic        ser_data,
   output frx_sample_t smp
);

   logic [2:0] staged;   // {clk, sync, data} after synchronisation
   logic       clk_prev;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [2:0] chain [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= {ser_clk, ser_sync, ser_data};
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign staged = chain[SYNC_STAGES-1];
      end else begin : g_direct
         assign staged = {ser_clk, ser_sync, ser_data};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= staged[2];
   end

   always_comb begin
      smp.strobe = clk_prev & ~staged[2];
      smp.sync   = staged[1];
      smp.data   = staged[0];
   end

endmodule

// File: rtl/frx_deser.sv
module frx_deser
   import frx_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  frx_sample_t       smp,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_out,
   output logic [CNT_W-1:0]  owed
);

   localparam int BIT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] INC = CNT_W'(WORD_W / BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] shift_q;
   logic [BIT_W-1:0]  bit_q;
   logic              active, take, last, sync_ev;
   logic [BYTE_W-1:0] assembled;
   logic [CNT_W-1:0]  owed_nxt;

   always_comb begin
      active    = (owed != '0);
      take      = smp.strobe && active;
      last      = take && (bit_q == LAST_BIT);
      sync_ev   = smp.strobe && smp.sync;
      assembled = {shift_q[BYTE_W-2:0], smp.data};
      owed_nxt  = owed + (sync_ev ? INC : '0) - (last ? CNT_W'(1) : '0);
      byte_done = last;
      byte_out  = assembled;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         bit_q   <= '0;
         owed    <= '0;
      end else begin
         if (sync_ev && !active) begin
            shift_q <= '0;
            bit_q   <= '0;
         end else if (take) begin
            shift_q <= assembled;
            bit_q   <= last ? '0 : bit_q + BIT_W'(1);
         end
         owed <= owed_nxt;
      end
   end

   // R10: count moves only on a sampled falling edge
   assert_owed_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !smp.strobe |=> $stable(owed));

   // R5: idle bits leave the count at zero
   assert_idle_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp.strobe && !smp.sync && owed == '0) |=> owed == '0);

   // R3: a sync from idle announces one word
   assert_sync_adds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp.strobe && smp.sync && owed == '0) |=> owed == INC);

endmodule

// File: rtl/frx_byte_fifo.sv
module frx_byte_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   output logic [WIDTH-1:0] head,
   output logic             valid,
   input  logic             ready,
   output logic             overflow
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full, pop, accept;

   always_comb begin
      valid  = (cnt_q != '0);
      full   = (cnt_q == CNT_W'(DEPTH));
      pop    = valid && ready;
      accept = push && (!full || pop);
      head   = mem[rd_q];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q     <= '0;
         rd_q     <= '0;
         cnt_q    <= '0;
         overflow <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (accept) begin
            mem[wr_q] <= push_data;
            wr_q      <= (wr_q == PTR_MAX) ? '0 : wr_q + PTR_W'(1);
         end
         if (pop) rd_q <= (rd_q == PTR_MAX) ? '0 : rd_q + PTR_W'(1);
         if (accept && !pop)      cnt_q <= cnt_q + CNT_W'(1);
         else if (pop && !accept) cnt_q <= cnt_q - CNT_W'(1);
         if (push && !accept) overflow <= 1'b1;
      end
   end

   // R8: a stalled head byte is held
   assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(head)));

   // R9: overflow is sticky until reset
   assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

endmodule

// File: rtl/frx_receiver.sv
module frx_receiver
   import frx_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FIFO_DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_sync,
   input  logic              ser_data,
   output logic [BYTE_W-1:0] byte_data,
   output logic              byte_valid,
   input  logic              byte_ready,
   output logic [CNT_W-1:0]  bytes_owed,
   output logic              overflow
);

   localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("frx_receiver: BYTE_W must be at least 2");
      end
      if (WORD_W % BYTE_W != 0) begin : g_bad_word
         $error("frx_receiver: WORD_W must be a multiple of BYTE_W");
      end
      if ((1 << CNT_W) <= 2 * BYTES_PER_WORD) begin : g_bad_cnt
         $error("frx_receiver: CNT_W too narrow for two queued words");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("frx_receiver: FIFO_DEPTH must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("frx_receiver: SYNC_STAGES must not be negative");
      end
   endgenerate

   frx_sample_t       smp;
   logic              done;
   logic [BYTE_W-1:0] done_byte;

   frx_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_sync (ser_sync),
      .ser_data (ser_data),
      .smp      (smp)
   );

   frx_deser #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp       (smp),
      .byte_done (done),
      .byte_out  (done_byte),
      .owed      (bytes_owed)
   );

   frx_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (done),
      .push_data (done_byte),
      .head      (byte_data),
      .valid     (byte_valid),
      .ready     (byte_ready),
      .overflow  (overflow)
   );

endmodule

// File: tb/test_frx_receiver.sv
module test_frx_receiver;

   localparam time CLK_PERIOD = 10ns;
   localparam int  HALF       = 6;      // system cycles per bit-clock half
   localparam int  NVEC       = 6;
   // {sync rides on previous word's last bit, word}
   localparam logic [16:0] VEC [NVEC] = '{
      {1'b0, 16'hA5C3}, {1'b1, 16'h0F1E}, {1'b1, 16'hFFFF},
      {1'b0, 16'h0000}, {1'b1, 16'h8001}, {1'b0, 16'h3C96}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0, ser_sync = 1'b0, ser_data = 1'b0;
   logic [7:0] byte_data;
   logic       byte_valid;
   logic       byte_ready = 1'b1;
   logic [3:0] bytes_owed;
   logic       overflow;

   int   n_chk = 0, n_fail = 0;
   logic [7:0] got [64];
   int   got_n = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   frx_receiver i_frx_receiver (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sync(ser_sync),
      .ser_data(ser_data), .byte_data(byte_data), .byte_valid(byte_valid),
      .byte_ready(byte_ready), .bytes_owed(bytes_owed), .overflow(overflow)
   );

   always @(negedge clk) begin
      if (rst_n && byte_valid && byte_ready && got_n < 64) begin
         got[got_n] = byte_data;
         got_n++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic s, input logic d);
      @(posedge clk); #1;
      ser_clk = 1'b1; ser_sync = s; ser_data = d;
      repeat (HALF) @(posedge clk);
      #1 ser_clk = 1'b0;
      repeat (HALF) @(posedge clk);
      #1;
   endtask

   task automatic send_word(input logic [15:0] w, input logic sync_last);
      for (int b = 15; b >= 0; b--) send_bit((b == 0) ? sync_last : 1'b0, w[b]);
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      got_n = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 valid", byte_valid, 0);
      check("R1 owed", bytes_owed, 0);
      check("R1 overflow", overflow, 0);

      // R5 bits with nothing owed are dropped
      for (int i = 0; i < 12; i++) send_bit(1'b0, i[0]);
      repeat (4) @(posedge clk);
      check("R5 idle owed", bytes_owed, 0);
      check("R5 idle no byte", got_n, 0);

      // R2 R3 R4 R6 table of gapped and back-to-back words
      for (int v = 0; v < NVEC; v++) begin
         logic nxt_b2b;
         nxt_b2b = (v + 1 < NVEC) ? VEC[v+1][16] : 1'b0;
         if (!VEC[v][16]) begin
            send_bit(1'b0, 1'b1);
            send_bit(1'b1, 1'b1);
            check("R3 owed after sync", bytes_owed, 2);
         end
         send_word(VEC[v][15:0], nxt_b2b);
         check(nxt_b2b ? "R6 owed at overlap" : "R5 owed at word end",
               bytes_owed, nxt_b2b ? 2 : 0);
      end
      repeat (8) @(posedge clk);
      check("R4 byte count", got_n, 2 * NVEC);
      for (int v = 0; v < NVEC; v++) begin
         check("R4 upper byte", got[2*v],   VEC[v][15:8]);
         check("R4 lower byte", got[2*v+1], VEC[v][7:0]);
      end

      // R7 sync partway into a byte keeps collected bits
      got_n = 0;
      send_bit(1'b1, 1'b0);
      begin
         logic [31:0] s;
         s = 32'hB74D2E91;
         for (int b = 31; b >= 0; b--) begin
            send_bit(b == 28, s[b]);
            if (b == 28) check("R7 owed after mid sync", bytes_owed, 4);
            if (b == 24) check("R5 owed after byte", bytes_owed, 3);
         end
         repeat (8) @(posedge clk);
         check("R7 count", got_n, 4);
         check("R7 byte0", got[0], 8'hB7);
         check("R7 byte1", got[1], 8'h4D);
         check("R7 byte2", got[2], 8'h2E);
         check("R7 byte3", got[3], 8'h91);
         check("R7 owed end", bytes_owed, 0);
      end

      // R8 R9 stalled consumer and overflow
      got_n = 0;
      @(posedge clk); #1 byte_ready = 1'b0;
      send_bit(1'b1, 1'b0);
      send_word(16'h1234, 1'b0);
      check("R8 valid held", byte_valid, 1);
      check("R8 head byte", byte_data, 8'h12);
      repeat (20) @(posedge clk);
      check("R8 head stable", byte_data, 8'h12);
      check("R9 no overflow yet", overflow, 0);
      send_bit(1'b1, 1'b0);
      send_word(16'h5678, 1'b0);
      check("R9 overflow set", overflow, 1);
      @(posedge clk); #1 byte_ready = 1'b1;
      repeat (10) @(posedge clk);
      check("R9 kept bytes", got_n, 2);
      check("R9 first kept", got[0], 8'h12);
      check("R9 second kept", got[1], 8'h34);
      check("R9 sticky", overflow, 1);

      // R1 reset in mid-word clears count and flag
      send_bit(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b1);
      do_reset();
      check("R1 owed cleared", bytes_owed, 0);
      check("R1 overflow cleared", overflow, 0);
      send_bit(1'b1, 1'b0);
      send_word(16'hC35A, 1'b0);
      repeat (8) @(posedge clk);
      check("R1 post-reset count", got_n, 2);
      check("R1 post-reset upper", got[0], 8'hC3);
      check("R1 post-reset lower", got[1], 8'h5A);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule